// File: doc/BRIEF.md
# UART byte receiver

This block turns an asynchronous serial line into parallel bytes. The line rests high. Each frame has three parts: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The length of one bit is a parameter, given as a count of system clock cycles. Each completed byte appears on a parallel output, and a strobe marks it for exactly one clock cycle during the stop bit.

The line passes through a synchronizer before any logic uses it. A falling edge is confirmed half a bit later. From that point every bit is sampled at its centre, one bit period after the previous sample. The block returns to idle right after the stop-bit sample. This leaves half a bit period in which to catch a start bit that follows with no idle gap. The block has no reset port: the initial values of its registers leave it idle and waiting for a start bit.

Top module: `uart_byte_rx`

## Requirements
- R1: Starting from the initial register values, with the line held high, `rx_strobe` stays 0 and `rx_byte` reads 0x00.
- R2: With CLKS_PER_BIT = 10, each of the 256 byte values is received correctly. The first data bit after the start bit goes to `rx_byte[0]` and the eighth goes to `rx_byte[7]`.
- R3: `rx_strobe` stays 0 from the start bit through the end of the eighth data bit.
- R4: `rx_strobe` goes high for exactly one cycle per valid frame. That cycle falls inside the stop-bit period, and `rx_byte` already holds the new byte in that cycle.
- R5: A start bit that follows the stop bit directly, with no idle time, is received correctly. This holds for runs of back-to-back frames.
- R6: A low pulse shorter than half a bit period on an idle line gives no strobe and leaves `rx_byte` unchanged.
- R7: If the stop bit samples low, the frame gives no strobe. The receiver then waits until the line goes high again before it looks for a new start bit, and the next good frame is received correctly.
- R8: `rx_byte` changes only in a cycle where `rx_strobe` is 1. Between strobes it holds the last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| rx_byte | output | DATA_BITS | Last byte received |
| rx_strobe | output | 1 | One-cycle pulse marking a new byte on `rx_byte` |

## Verification
Two events can fall in the same stop-bit period: the strobe for the byte just finished, and the detection of the next start bit. The back-to-back run provokes this by sending 256 frames whose start bits begin on the clock cycle right after each stop bit ends. Each frame is judged on its own terms: exactly one strobe, seen only while the stop bit is on the line, and carrying that frame's byte. The bad-stop case provokes a related collision, in which a low line at the stop-bit sample must not be taken as a new start bit.

// File: rtl/uart_byte_rx_pkg.sv
package uart_byte_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_BREAK = 3'd4
  } rx_state_e;
endpackage

// File: rtl/uart_byte_rx_sync.sv
module uart_byte_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);
  // Stages start high so that power-up looks like an idle line.
  logic [STAGES-1:0] stage = '1;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) stage[0] <= d_async;
    end else begin : g_many
      always_ff @(posedge clk) stage <= {stage[STAGES-2:0], d_async};
    end
  endgenerate

  assign q_sync = stage[STAGES-1];
endmodule

// File: rtl/uart_byte_rx_timer.sv
module uart_byte_rx_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt = '0;

  always_ff @(posedge clk) begin
    if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/uart_byte_rx_shift.sv
module uart_byte_rx_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word
);
  logic [WIDTH-1:0] sr = '0;

  // Bits arrive LSB first: each new bit enters at the top and moves down.
  always_ff @(posedge clk) begin
    if (shift_en)
      sr <= {bit_in, sr[WIDTH-1:1]};
  end

  assign word = sr;
endmodule

// File: rtl/uart_byte_rx.sv
module uart_byte_rx
  import uart_byte_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int DATA_BITS    = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_strobe
);
  localparam int CNT_W  = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIDX_W = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0]  HALF_LD = CNT_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0]  FULL_LD = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [BIDX_W-1:0] LAST_IX = BIDX_W'(DATA_BITS - 1);

  logic                 line_s;
  logic                 tmr_load;
  logic [CNT_W-1:0]     tmr_val;
  logic                 tmr_done;
  logic                 shift_en;
  logic [DATA_BITS-1:0] shift_word;

  rx_state_e             state     = ST_IDLE;
  rx_state_e             state_nx;
  logic [BIDX_W-1:0]     bit_ix    = '0;
  logic [DATA_BITS-1:0]  byte_q    = '0;
  logic                  strobe_q  = 1'b0;

  uart_byte_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (rx_line),
    .q_sync  (line_s)
  );

  uart_byte_rx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  uart_byte_rx_shift #(.WIDTH(DATA_BITS)) u_shift (
    .clk      (clk),
    .shift_en (shift_en),
    .bit_in   (line_s),
    .word     (shift_word)
  );

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = FULL_LD;
    shift_en = 1'b0;
    unique case (state)
      ST_IDLE: if (!line_s) begin
        tmr_load = 1'b1;
        tmr_val  = HALF_LD;
        state_nx = ST_START;
      end
      ST_START: if (tmr_done) begin
        if (!line_s) begin
          tmr_load = 1'b1;
          state_nx = ST_DATA;
        end else begin
          state_nx = ST_IDLE;
        end
      end
      ST_DATA: if (tmr_done) begin
        shift_en = 1'b1;
        tmr_load = 1'b1;
        if (bit_ix == LAST_IX) state_nx = ST_STOP;
      end
      ST_STOP: if (tmr_done) begin
        state_nx = line_s ? ST_IDLE : ST_BREAK;
      end
      ST_BREAK: if (line_s) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    state    <= state_nx;
    strobe_q <= 1'b0;
    if (state == ST_START)
      bit_ix <= '0;
    else if (shift_en)
      bit_ix <= bit_ix + 1'b1;
    if (state == ST_STOP && tmr_done && line_s) begin
      strobe_q <= 1'b1;
      byte_q   <= shift_word;
    end
  end

  assign rx_byte   = byte_q;
  assign rx_strobe = strobe_q;
endmodule

// File: rtl/uart_byte_rx_chk.sv
module uart_byte_rx_chk #(
  parameter int CLKS_PER_BIT = 10,
  parameter int DATA_BITS    = 8
) (
  input logic                 clk,
  input logic                 line_s,
  input logic                 rx_strobe,
  input logic [DATA_BITS-1:0] rx_byte
);
  localparam int MIN_GAP = (DATA_BITS + 1) * CLKS_PER_BIT;
  localparam int GAP_MAX = (DATA_BITS + 2) * CLKS_PER_BIT;

  logic warm = 1'b0;
  int   since = GAP_MAX;

  always_ff @(posedge clk) begin
    warm <= 1'b1;
    if (rx_strobe)
      since <= 1;
    else if (since < GAP_MAX)
      since <= since + 1;
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!warm)
    rx_strobe |=> !rx_strobe); // R4

  AST_BYTE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!warm)
    (rx_byte != $past(rx_byte)) |-> rx_strobe); // R8

  AST_STOP_SEEN_HIGH: assert property (@(posedge clk) disable iff (!warm)
    rx_strobe |-> $past(line_s)); // R7

  AST_FRAME_SPACING: assert property (@(posedge clk) disable iff (!warm)
    rx_strobe |-> (since >= MIN_GAP)); // R3
endmodule

bind uart_byte_rx uart_byte_rx_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .DATA_BITS   (DATA_BITS)
) u_chk (
  .clk       (clk),
  .line_s    (line_s),
  .rx_strobe (rx_strobe),
  .rx_byte   (rx_byte)
);

// File: tb/uart_byte_rx_tb.sv
`timescale 1ns/1ps
module uart_byte_rx_tb;
  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rx  = 1'b1;
  logic [7:0] rbyte;
  logic       strobe;
  int         total = 0;
  int         bad   = 0;
  bit         done  = 1'b0;

  always #4 clk = ~clk;

  uart_byte_rx #(.CLKS_PER_BIT(P), .DATA_BITS(8)) u_dut (
    .clk       (clk),
    .rx_line   (rx),
    .rx_byte   (rbyte),
    .rx_strobe (strobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drives one frame, cycle by cycle, and watches the strobe.
  task automatic send_frame(input logic [7:0] b, input logic stop_v,
                            output int n_str, output int n_early, output logic [7:0] got);
    n_str = 0; n_early = 0; got = '0;
    for (int i = 0; i < 10 * P; i++) begin
      int bi;
      bi = i / P;
      if (bi == 0)      rx = 1'b0;
      else if (bi < 9)  rx = b[bi-1];
      else              rx = stop_v;
      @(negedge clk);
      if (strobe) begin
        n_str++;
        if (bi < 9) n_early++;
        got = rbyte;
      end
    end
  endtask

  task automatic idle_cycles(input int n, input logic lvl, output int n_str);
    n_str = 0;
    rx = lvl;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (strobe) n_str++;
    end
  endtask

  task automatic frame_checked(input logic [7:0] b, input string tag);
    int ns, ne;
    logic [7:0] got;
    send_frame(b, 1'b1, ns, ne, got);
    check(ne == 0, {"R3 ", tag}, ne, 0);
    check(ns == 1, {"R4 ", tag}, ns, 1);
    check(got == b, {"R2 ", tag}, got, b);
  endtask

  task automatic t_power_up();
    int ns;
    idle_cycles(30, 1'b1, ns);
    check(ns == 0, "R1 strobe idle", ns, 0);
    check(rbyte == 8'h00, "R1 byte initial", rbyte, 0);
  endtask

  task automatic t_all_bytes_gap();
    int ns;
    for (int v = 0; v < 256; v++) begin
      frame_checked(8'(v), "gap");
      idle_cycles(3 * P, 1'b1, ns);
      check(ns == 0, "R4 no strobe in gap", ns, 0);
    end
  endtask

  task automatic t_back_to_back();
    for (int v = 0; v < 256; v++)
      frame_checked(8'(255 - v), "R5 back-to-back");
  endtask

  task automatic t_hold();
    int ns;
    frame_checked(8'h3C, "hold");
    idle_cycles(5 * P, 1'b1, ns);
    check(ns == 0, "R8 no strobe while idle", ns, 0);
    check(rbyte == 8'h3C, "R8 byte held", rbyte, 8'h3C);
  endtask

  task automatic t_glitch();
    int ns, ns2;
    idle_cycles(2, 1'b0, ns);
    idle_cycles(3 * P, 1'b1, ns2);
    check(ns + ns2 == 0, "R6 glitch strobe", ns + ns2, 0);
    check(rbyte == 8'h3C, "R6 byte unchanged", rbyte, 8'h3C);
    frame_checked(8'h96, "R6 after glitch");
  endtask

  task automatic t_bad_stop();
    int ns, ne, n2, n3;
    logic [7:0] got;
    send_frame(8'h5A, 1'b0, ns, ne, got);
    idle_cycles(3 * P, 1'b0, n2);
    idle_cycles(2 * P, 1'b1, n3);
    check(ns + n2 + n3 == 0, "R7 no strobe on bad stop", ns + n2 + n3, 0);
    check(rbyte == 8'h96, "R7 byte unchanged", rbyte, 8'h96);
    frame_checked(8'hA5, "R7 recovery");
  endtask

  initial begin
    @(negedge clk);
    t_power_up();
    t_all_bytes_gap();
    t_back_to_back();
    t_hold();
    t_glitch();
    t_bad_stop();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule